// File: doc/BRIEF.md
# Decimating FIR Filter Core with Flush and Soft Reset

This core filters a stream of signed samples with a short FIR kernel and keeps only one result in every D accepted samples. Samples enter through a one-deep input buffer that raises a request whenever it can take a word. Each time the decimation counter wraps, a serial multiply-accumulate walks the tap line one tap per clock. The finished sum is then posted into a one-deep output buffer, which signals that data is ready until the consumer pops it.

A small register bus sets the coefficients, the control fields and the status readback. Two control operations clear state in different ways. A flush wipes only the filter history: the tap line and the decimation counter. Soft reset returns the whole datapath to idle within two cycles. It drops buffered input, unread output and any sum in progress. Neither operation touches the coefficients or the control fields.

Top module: `dfir_core`

## Requirements
- R1: Coefficient k (the weight for the sample k positions back, k=0 newest) is written at register address 8+k as an 8-bit signed value. It reads back zero-extended, resets to 0, and is left unchanged by flush and by soft reset.
- R2: The control register at address 0 holds mode in bits [1:0] (00 = filter off, any other value = on), input-disable in bit 2, a soft-reset trigger in bit 3 and the decimation factor minus one in bits [7:4]. Bit 3 always reads 0. The other fields keep their written value through a soft reset.
- R3: Each output equals the signed sum of c[k]*x[n-k] over the 4 taps, presented as an 18-bit signed value with out_rdy high. out_pop clears out_rdy. A newer result overwrites an unread one.
- R4: With factor field F, one output follows every (F+1)th accepted sample. The count of accepted samples since the last output reads in status bits [4:1].
- R5: A flush (flush_req pulse while the mode is on) zeroes all taps and the decimation count. It leaves the coefficients alone, and an unread output stays readable and unchanged.
- R6: A flush requested in the same cycle as a sample is applied before that sample, so the sample is filtered on an empty history.
- R7: With mode 00, a flush request is ignored: it is not held pending (status bit 7 stays 0) and the history survives.
- R8: A write of 1 to control bit 3 holds busy high for exactly the two cycles after the write edge, with in_req low. Busy is low on the third cycle.
- R9: Soft reset aborts a sum in progress without posting it. It empties the input and output buffers and zeroes the taps and the decimation count, so status reads 0 afterwards.
- R10: With input-disable set, in_req stays low and no sample is taken. A sample already buffered is still filtered, and busy stays high until its result is posted.
- R11: After rst_n, status reads 0 and busy, out_rdy and in_req are low.
- R12: in_req is high exactly when the input buffer is empty, the mode is on, input-disable is clear and no soft reset is running. A sample is taken on a clock edge where smp_valid and in_req are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| cfg_wr | input | 1 | register write strobe |
| cfg_addr | input | 5 | register address |
| cfg_wdata | input | 8 | register write data |
| cfg_rdata | output | 8 | register read data (combinational) |
| smp_valid | input | 1 | sample offered |
| smp_data | input | 8 | signed sample |
| flush_req | input | 1 | flush request pulse |
| in_req | output | 1 | input buffer can take a sample |
| out_rdy | output | 1 | output buffer holds a result |
| out_data | output | 18 | signed filter result |
| out_pop | input | 1 | consumer takes the result |
| busy | output | 1 | sample, flush or soft reset in progress |

## Verification
Decimation factors 1 to 4 are each swept with two mixed-sign coefficient sets and a strided sample ramp that crosses zero. This separates errors in tap order, sign handling and output spacing. A saturating case with every coefficient and sample at -128 exposes any lost sign bit or short accumulator. Flush is tried alone in the middle of a decimation count, together with a sample, and with the filter off; comparing the following output against a model with and without cleared history tells the three apart. Soft reset is tried against an unread result, a sum in flight and a buffered sample, and input-disable against a sample already in the buffer.

// File: rtl/dfir_pkg.sv
// Shared constants for the decimating FIR core: register width and address map.
package dfir_pkg;
    localparam int unsigned REG_W   = 8;
    localparam int unsigned A_CTRL  = 0;
    localparam int unsigned A_STAT  = 1;
    localparam int unsigned A_COEF0 = 8;

    // Control register layout (MSB first).
    typedef struct packed {
        logic [3:0] dec_m1;
        logic       srst;
        logic       in_dis;
        logic [1:0] mode;
    } ctrl_t;
endpackage

// File: rtl/dfir_regs.sv
// Register file: control fields, coefficient bank, status readback and the
// two-cycle soft-reset sequencer. Assumes CW <= REG_W and A_COEF0+NTAP fits AW.
module dfir_regs
    import dfir_pkg::*;
#(
    parameter int unsigned NTAP = 4,
    parameter int unsigned CW   = 8,
    parameter int unsigned AW   = 5
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic [AW-1:0]            cfg_addr,
    input  logic [REG_W-1:0]         cfg_wdata,
    input  logic [REG_W-1:0]         stat,
    output logic [REG_W-1:0]         cfg_rdata,
    output logic [1:0]               mode,
    output logic                     in_dis,
    output logic [3:0]               dec_m1,
    output logic [NTAP-1:0][CW-1:0]  coefs,
    output logic                     sr_active
);
    ctrl_t      ctrl_q;
    logic [1:0] sr_cnt;
    logic       wr_ctrl;

    assign wr_ctrl   = cfg_wr && (cfg_addr == AW'(A_CTRL));
    assign mode      = ctrl_q.mode;
    assign in_dis    = ctrl_q.in_dis;
    assign dec_m1    = ctrl_q.dec_m1;
    assign sr_active = (sr_cnt != 2'd0);

    // Control fields; the soft-reset bit is never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q      <= ctrl_t'(cfg_wdata);
            ctrl_q.srst <= 1'b0;
        end
    end

    // Soft-reset sequencer: loads 2 on the trigger, then counts down.
    always_ff @(posedge clk) begin
        if (!rst_n)                      sr_cnt <= 2'd0;
        else if (wr_ctrl && cfg_wdata[3]) sr_cnt <= 2'd2;
        else if (sr_cnt != 2'd0)          sr_cnt <= sr_cnt - 2'd1;
    end

    // Coefficient bank, one register per tap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coefs <= '0;
        end else begin
            for (int k = 0; k < NTAP; k++)
                if (cfg_wr && (cfg_addr == AW'(A_COEF0 + k)))
                    coefs[k] <= cfg_wdata[CW-1:0];
        end
    end

    // Read mux.
    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == AW'(A_CTRL))      cfg_rdata = REG_W'(ctrl_q);
        else if (cfg_addr == AW'(A_STAT)) cfg_rdata = stat;
        for (int k = 0; k < NTAP; k++)
            if (cfg_addr == AW'(A_COEF0 + k)) cfg_rdata = REG_W'(coefs[k]);
    end

    // R1: a soft reset with no bus write leaves the coefficient bank alone.
    a_r1_coef_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_active && !cfg_wr) |=> $stable(coefs));
endmodule

// File: rtl/dfir_taps.sv
// Tap delay line, index 0 newest. A clear and a shift in the same cycle
// clear first, then shift the new sample in. Assumes NTAP >= 2.
module dfir_taps #(
    parameter int unsigned NTAP = 4,
    parameter int unsigned DW   = 8
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     shift,
    input  logic [DW-1:0]            din,
    output logic [NTAP-1:0][DW-1:0]  taps
);
    logic [NTAP-1:0][DW-1:0] nxt;

    // Next line contents: optional clear, then optional shift.
    always_comb begin
        nxt = clr ? '0 : taps;
        if (shift) nxt = {nxt[NTAP-2:0], din};
    end

    // Delay line register.
    always_ff @(posedge clk) begin
        if (!rst_n) taps <= '0;
        else        taps <= nxt;
    end

    // R5: a lone clear leaves an empty history.
    a_r5_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !shift) |=> (taps == '0));
    // R6: clear with a sample keeps only that sample.
    a_r6_flush_first: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && shift) |=> (taps[NTAP-1:1] == '0));
endmodule

// File: rtl/dfir_mac.sv
// Serial multiply-accumulate, one tap per clock, and the one-deep output buffer.
// Assumes taps and coefs stay stable while run is high.
module dfir_mac #(
    parameter int unsigned NTAP = 4,
    parameter int unsigned DW   = 8,
    parameter int unsigned CW   = 8,
    parameter int unsigned OW   = 18
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     abort,
    input  logic                     pop,
    input  logic [NTAP-1:0][DW-1:0]  taps,
    input  logic [NTAP-1:0][CW-1:0]  coefs,
    output logic                     run,
    output logic                     out_rdy,
    output logic [OW-1:0]            out_data
);
    localparam int unsigned IW = $clog2(NTAP);
    localparam int unsigned PW = DW + CW;
    localparam logic [IW-1:0] LAST = IW'(NTAP - 1);

    logic [IW-1:0]        idx;
    logic signed [OW-1:0] acc;
    logic signed [PW-1:0] a_x, b_x, prod;
    logic signed [OW-1:0] sum;
    logic                 post;

    // Product of the current tap and its weight, sign-extended.
    always_comb begin
        a_x  = PW'($signed(taps[idx]));
        b_x  = PW'($signed(coefs[idx]));
        prod = a_x * b_x;
        sum  = acc + OW'(prod);
        post = run && (idx == LAST);
    end

    // Accumulator sequence and output buffer.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            run      <= 1'b0;
            idx      <= '0;
            acc      <= '0;
            out_rdy  <= 1'b0;
            out_data <= '0;
        end else begin
            if (pop) out_rdy <= 1'b0;
            if (start) begin
                run <= 1'b1;
                idx <= '0;
                acc <= '0;
            end else if (run) begin
                acc <= sum;
                idx <= idx + 1'b1;
                if (post) begin
                    run      <= 1'b0;
                    out_data <= sum;
                    out_rdy  <= 1'b1;
                end
            end
        end
    end

    // R5: an unread result stays put until popped, replaced or reset.
    a_r5_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_rdy && !pop && !abort && !post) |=> (out_rdy && $stable(out_data)));
endmodule

// File: rtl/dfir_core.sv
// Decimating FIR core: input buffer, flush and decimation control around the
// register file, tap line and serial MAC. Soft reset overrides everything.
module dfir_core
    import dfir_pkg::*;
#(
    parameter int unsigned NTAP = 4,
    parameter int unsigned DW   = 8,
    parameter int unsigned CW   = 8,
    parameter int unsigned AW   = 5,
    localparam int unsigned OW  = DW + CW + $clog2(NTAP)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             smp_valid,
    input  logic [DW-1:0]    smp_data,
    input  logic             flush_req,
    output logic             in_req,
    output logic             out_rdy,
    output logic [OW-1:0]    out_data,
    input  logic             out_pop,
    output logic             busy
);
    logic [1:0]              mode;
    logic                    in_dis, sr_active, mac_run, enabled;
    logic [3:0]              dec_m1, dcnt, base;
    logic [NTAP-1:0][CW-1:0] coefs;
    logic [NTAP-1:0][DW-1:0] taps;
    logic                    ibuf_full, flush_pend;
    logic [DW-1:0]           ibuf_data;
    logic                    idle, take, apply_flush, wrap, accept;
    logic [REG_W-1:0]        stat;

    assign enabled     = (mode != 2'b00);
    assign idle        = !mac_run && !sr_active;
    assign take        = idle && ibuf_full;
    assign apply_flush = idle && flush_pend;
    assign base        = apply_flush ? 4'd0 : dcnt;
    assign wrap        = take && (base >= dec_m1);
    assign in_req      = !ibuf_full && !in_dis && enabled && !sr_active;
    assign accept      = smp_valid && in_req;
    assign busy        = sr_active || ibuf_full || mac_run || flush_pend;
    assign stat        = {flush_pend, out_rdy, ibuf_full, dcnt, busy};

    // One-deep input buffer.
    always_ff @(posedge clk) begin
        if (!rst_n || sr_active) begin
            ibuf_full <= 1'b0;
            ibuf_data <= '0;
        end else if (accept) begin
            ibuf_full <= 1'b1;
            ibuf_data <= smp_data;
        end else if (take) begin
            ibuf_full <= 1'b0;
        end
    end

    // Pending flush, accepted only while the filter is on.
    always_ff @(posedge clk) begin
        if (!rst_n || sr_active) flush_pend <= 1'b0;
        else flush_pend <= (flush_pend && !apply_flush) || (flush_req && enabled);
    end

    // Decimation counter of taken samples.
    always_ff @(posedge clk) begin
        if (!rst_n || sr_active) dcnt <= 4'd0;
        else if (take)           dcnt <= wrap ? 4'd0 : base + 4'd1;
        else if (apply_flush)    dcnt <= 4'd0;
    end

    dfir_regs #(.NTAP(NTAP), .CW(CW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .stat(stat), .cfg_rdata(cfg_rdata),
        .mode(mode), .in_dis(in_dis), .dec_m1(dec_m1), .coefs(coefs),
        .sr_active(sr_active)
    );

    dfir_taps #(.NTAP(NTAP), .DW(DW)) u_taps (
        .clk(clk), .rst_n(rst_n), .clr(sr_active || apply_flush),
        .shift(take), .din(ibuf_data), .taps(taps)
    );

    dfir_mac #(.NTAP(NTAP), .DW(DW), .CW(CW), .OW(OW)) u_mac (
        .clk(clk), .rst_n(rst_n), .start(wrap), .abort(sr_active),
        .pop(out_pop), .taps(taps), .coefs(coefs), .run(mac_run),
        .out_rdy(out_rdy), .out_data(out_data)
    );

    // R9: after a soft-reset cycle every buffer and counter is empty.
    a_r9_sres_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active |=> (!ibuf_full && !out_rdy && dcnt == 4'd0 && !mac_run && !flush_pend));
    // R8: the soft reset lasts at least two cycles.
    a_r8_sres_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_active) |=> sr_active);
    // R7: with the filter off no flush becomes pending.
    a_r7_flush_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled && !flush_pend) |=> !flush_pend);
    // R10: input-disable keeps an empty buffer empty.
    a_r10_indis_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (in_dis && !ibuf_full) |=> !ibuf_full);
endmodule

// File: tb/sim_dfir_core.sv
module sim_dfir_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        smp_valid = 1'b0;
    logic [7:0]  smp_data = '0;
    logic        flush_req = 1'b0;
    logic        in_req, out_rdy, out_pop = 1'b0, busy;
    logic [17:0] out_data;

    int checks = 0, fails = 0;
    int hist[4];
    int cf[4];
    int cnt = 0, dfac = 1;
    bit mode_on = 0;
    int g_mode = 0, g_dis = 0, g_dm1 = 0;
    bit exp_flag;
    int exp_val;
    bit done = 0;

    always #4 clk = ~clk;

    dfir_core u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .smp_valid(smp_valid),
        .smp_data(smp_data), .flush_req(flush_req), .in_req(in_req),
        .out_rdy(out_rdy), .out_data(out_data), .out_pop(out_pop), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 5'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        cfg_addr = 5'(a);
        #1 d = int'(cfg_rdata);
    endtask

    task automatic set_ctrl(input int m, input int dis, input int dm1);
        g_mode = m; g_dis = dis; g_dm1 = dm1;
        mode_on = (m != 0);
        dfac = dm1 + 1;
        wr(0, (dm1 << 4) | (dis << 2) | m);
    endtask

    task automatic model_clear();
        for (int k = 0; k < 4; k++) hist[k] = 0;
        cnt = 0;
    endtask

    // Soft reset keeping the control fields; checks the busy window (R8).
    task automatic do_srst();
        int b1, b2, b3, r1, r2;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 5'd0;
        cfg_wdata = 8'((g_dm1 << 4) | 8 | (g_dis << 2) | g_mode);
        @(negedge clk);
        cfg_wr = 1'b0;
        #1 b1 = busy; r1 = in_req;
        @(negedge clk); #1 b2 = busy; r2 = in_req;
        @(negedge clk); #1 b3 = busy;
        chk(b1 == 1 && b2 == 1, "R8 busy during soft reset", b1 + b2, 2);
        chk(b3 == 0, "R8 busy low on third cycle", b3, 0);
        chk(r1 == 0 && r2 == 0, "R8 in_req low during soft reset", r1 + r2, 0);
        model_clear();
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        #1;
        while (busy && n < 200) begin
            @(negedge clk); #1; n++;
        end
        if (n >= 200) chk(0, "busy timeout", 1, 0);
    endtask

    task automatic flush_pulse();
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        if (mode_on) model_clear();
    endtask

    // Offer one sample (optionally with a flush) and update the model.
    task automatic push(input int s, input bit fl);
        int n = 0;
        @(negedge clk);
        while (!in_req && n < 200) begin
            @(negedge clk); n++;
        end
        if (n >= 200) chk(0, "R12 in_req timeout", 0, 1);
        smp_valid = 1'b1; smp_data = 8'(s); flush_req = fl;
        @(negedge clk);
        smp_valid = 1'b0; flush_req = 1'b0;
        if (fl && mode_on) model_clear();
        for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = s;
        exp_flag = 0;
        if (cnt >= dfac - 1) begin
            cnt = 0;
            exp_flag = 1;
            exp_val = 0;
            for (int k = 0; k < 4; k++) exp_val += hist[k] * cf[k];
        end else begin
            cnt++;
        end
    endtask

    task automatic pop();
        @(negedge clk);
        out_pop = 1'b1;
        @(negedge clk);
        out_pop = 1'b0;
    endtask

    task automatic check_out(input string req);
        int got;
        got = int'($signed(out_data));
        if (exp_flag) begin
            chk(out_rdy == 1'b1, {req, " out_rdy"}, int'(out_rdy), 1);
            chk(got == exp_val, {req, " out_data"}, got, exp_val);
            pop();
            #1 chk(out_rdy == 1'b0, "R3 pop clears out_rdy", int'(out_rdy), 0);
        end else begin
            chk(out_rdy == 1'b0, {req, " no output"}, int'(out_rdy), 0);
        end
    endtask

    task automatic push_check(input int s, input bit fl, input string req);
        push(s, fl);
        wait_idle();
        check_out(req);
    endtask

    task automatic load_coefs(input int j);
        for (int k = 0; k < 4; k++) begin
            cf[k] = ((k * 53 + j * 29 + 7) % 256) - 128;
            wr(8 + k, cf[k] & 255);
        end
    endtask

    task automatic check_coefs(input string req);
        int d;
        for (int k = 0; k < 4; k++) begin
            rd(8 + k, d);
            chk(d == (cf[k] & 255), req, d, cf[k] & 255);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog expired", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int d, v, got, n;
        for (int k = 0; k < 4; k++) cf[k] = 0;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11 reset state
        rd(1, d);
        chk(d == 0, "R11 status after reset", d, 0);
        chk(busy == 0 && out_rdy == 0 && in_req == 0, "R11 outputs after reset",
            int'(busy) + int'(out_rdy) + int'(in_req), 0);
        rd(8, d);
        chk(d == 0, "R1 coefficient reset value", d, 0);

        // R1 coefficient write and readback
        load_coefs(0);
        check_coefs("R1 coefficient readback");

        // R12 request follows mode
        set_ctrl(1, 0, 0);
        #1 chk(in_req == 1, "R12 in_req with filter on", int'(in_req), 1);

        // R3/R4 sweep over decimation factors and coefficient sets
        for (int f = 1; f <= 4; f++) begin
            for (int j = 0; j < 2; j++) begin
                load_coefs(j + f);
                set_ctrl(1 + j, 0, f - 1);
                do_srst();
                for (int i = 0; i < 12; i++)
                    push_check(((i * 71 + f * 13) % 256) - 128, 0, "R3 R4 sweep");
            end
        end

        // R3 boundary: all weights and samples at the negative extreme
        for (int k = 0; k < 4; k++) begin cf[k] = -128; wr(8 + k, 128); end
        set_ctrl(1, 0, 0);
        do_srst();
        for (int i = 0; i < 4; i++) push_check(-128, 0, "R3 negative extreme");

        // R4 status count, R5 lone flush resets it
        load_coefs(5);
        set_ctrl(1, 0, 3);
        do_srst();
        push_check(17, 0, "R4 count 1");
        push_check(-9, 0, "R4 count 2");
        rd(1, d);
        chk(((d >> 1) & 15) == 2, "R4 status count", (d >> 1) & 15, 2);
        flush_pulse();
        wait_idle();
        rd(1, d);
        chk(((d >> 1) & 15) == 0, "R5 flush resets count", (d >> 1) & 15, 0);
        for (int i = 0; i < 4; i++) push_check(i * 30 - 50, 0, "R5 output after flush");

        // R6 flush with a sample
        set_ctrl(1, 0, 0);
        push_check(100, 0, "R6 prefill");
        push_check(-77, 0, "R6 prefill");
        push_check(55, 0, "R6 prefill");
        push_check(33, 1, "R6 flush before sample");

        // R5 flush keeps an unread result and the coefficients
        push(-44, 0);
        wait_idle();
        v = int'($signed(out_data));
        chk(out_rdy == 1 && v == exp_val, "R5 result before flush", v, exp_val);
        flush_pulse();
        wait_idle();
        got = int'($signed(out_data));
        chk(out_rdy == 1, "R5 out_rdy kept by flush", int'(out_rdy), 1);
        chk(got == v, "R5 out_data kept by flush", got, v);
        check_coefs("R5 R1 coefficients kept by flush");
        pop();

        // R7 flush ignored with filter off
        push_check(12, 0, "R7 prefill");
        push_check(-90, 0, "R7 prefill");
        push_check(64, 0, "R7 prefill");
        set_ctrl(0, 0, 0);
        flush_pulse();
        rd(1, d);
        chk(((d >> 7) & 1) == 0, "R7 no pending flush", (d >> 7) & 1, 0);
        set_ctrl(1, 0, 0);
        push_check(-3, 0, "R7 history kept");

        // R9 soft reset drops an unread result
        push(21, 0);
        wait_idle();
        chk(out_rdy == 1, "R9 result present", int'(out_rdy), 1);
        do_srst();
        #1 chk(out_rdy == 0, "R9 unread result dropped", int'(out_rdy), 0);
        rd(1, d);
        chk(d == 0, "R9 status cleared", d, 0);
        rd(0, d);
        chk(d == 1, "R2 control kept, trigger reads 0", d, 1);
        check_coefs("R1 coefficients kept by soft reset");

        // R9 soft reset aborts a sum in flight
        push(99, 0);
        do_srst();
        wait_idle();
        chk(out_rdy == 0, "R9 aborted sum not posted", int'(out_rdy), 0);
        push_check(5, 0, "R9 history cleared");

        // R10 input disable with a buffered sample
        push(-60, 0);
        #1 chk(busy == 1, "R10 busy with buffered sample", int'(busy), 1);
        set_ctrl(1, 1, 0);
        #1 chk(in_req == 0, "R10 in_req low when disabled", int'(in_req), 0);
        n = 0;
        while (busy && n < 100) begin @(negedge clk); #1; n++; end
        chk(out_rdy == 1, "R10 busy low only after result", int'(out_rdy), 1);
        got = int'($signed(out_data));
        chk(got == exp_val, "R10 buffered sample filtered", got, exp_val);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = 8'd77;
        repeat (8) @(negedge clk);
        smp_valid = 1'b0;
        rd(1, d);
        chk(d == 64, "R10 no sample taken while disabled", d, 64);
        pop();
        set_ctrl(1, 0, 0);
        push_check(7, 0, "R10 history after disable");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule